// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Model

This block is a synthesizable model of a word-organised static RAM. Its control pins behave like those of a stand-alone asynchronous memory: two chip enables of opposite polarity, a write strobe, an output strobe and separate active-low enables for the upper and lower byte. The bidirectional data pins are split into an input bus, an output bus and one drive flag per byte lane. A chip-level tristate pad, or a bench, joins them back into one bus.

Each byte lane is decoded on its own into standby, idle (outputs off), read or write. Reads are combinational: the addressed word appears on the output bus in the same cycle that the read controls are applied. A write opens a window while the device is selected, the write strobe is low and the lane's enable is low. The lane's byte is committed when that window closes, using the address and data seen on the last clock edge at which the window was still open. A standby flag reports the power-down decode. Storage depth is a parameter. The address is cut to the low log2(depth) bits, so a small array can stand in for the full 256K-word part in simulation.

Top module: `bls_sram`

## Requirements
- R1: The device is selected only when `ce_n` is 0 and `ce` is 1. Every other combination deselects it: `standby` is 1, neither lane drives, and no write takes place.
- R2: When both `ub_n` and `lb_n` are 1, `standby` is 1 and neither lane drives. The levels of `we_n`, `oe_n`, address and data then have no effect, and no byte is stored.
- R3: Read mode is selected with `we_n`=1 and `oe_n`=0. In read mode `drv_lo` equals the inverse of `lb_n` and `drv_hi` equals the inverse of `ub_n`. Each driven lane shows its byte of the stored word at the current address in the same cycle: bits 7:0 carry the low lane and bits 15:8 the high lane.
- R4: During a read, a lane whose enable is 1 stays undriven while the other lane drives.
- R5: When the device is selected with `we_n`=1, `oe_n`=1 and at least one byte enable at 0, neither lane drives and `standby` is 0.
- R6: When the device is selected with `we_n`=0, at any level of `oe_n`, neither lane drives. Only the lanes whose enable is 0 are written, and the other lane of the word keeps its contents.
- R7: A lane's write window is open on each rising clock edge where the device is selected, `we_n` is 0 and that lane's enable is 0. The byte is stored on the first edge at which the window is found closed. The stored byte and address are those sampled on the last edge with the window open. Reads show the new byte from that edge onward, and not before.
- R8: Only address bits below log2(DEPTH) select a word. Addresses that differ only in higher bits reach the same word.
- R9: The output bits of a lane that does not drive read as 0.
- R10: While `rst_n` is 0, no write window is held open. A window that is open when reset asserts commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; samples write windows |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Active-low chip enable |
| ce | input | 1 | Active-high chip enable |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| ub_n | input | 1 | Active-low upper byte enable (bits 15:8) |
| lb_n | input | 1 | Active-low lower byte enable (bits 7:0) |
| din | input | 16 | Write data from the pads |
| dout | output | 16 | Read data toward the pads |
| drv_lo | output | 1 | Lower lane drives the pads |
| drv_hi | output | 1 | Upper lane drives the pads |
| standby | output | 1 | Power-down decode active |

## Verification
The hardest case to reach from the ports is a write whose lanes close their windows on different edges, with data and address changing while a window is still open. A related case is a window that is open at the moment reset asserts. Directed sequences build each of these. They hold a window across several cycles with changing data, end the windows through each of the four possible causes (chip enable, write strobe, byte enable and reset), and read the word back after closing. Long stretches of random control and data over a narrow address range then compare every cycle against a behavioural model, to cover the mixed cases.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    LANE_STBY  = 2'd0,
    LANE_IDLE  = 2'd1,
    LANE_READ  = 2'd2,
    LANE_WRITE = 2'd3
  } lane_mode_e;
endpackage

// File: rtl/bls_decode.sv
module bls_decode
  import bls_pkg::*;
(
  input  logic             ce_n,
  input  logic             ce,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] ben_n,
  output lane_mode_e       mode_o [LANES],
  output logic             standby_o
);
  logic sel;
  logic stby;

  always_comb begin
    sel  = ~ce_n & ce;
    stby = ~sel | (&ben_n);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      if (stby)              mode_o[l] = LANE_STBY;
      else if (ben_n[l])     mode_o[l] = LANE_IDLE;
      else if (!we_n)        mode_o[l] = LANE_WRITE;
      else if (!oe_n)        mode_o[l] = LANE_READ;
      else                   mode_o[l] = LANE_IDLE;
    end
  end

  assign standby_o = stby;
endmodule

// File: rtl/bls_lane_commit.sv
module bls_lane_commit #(
  parameter int IDX_W  = 8,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LANE_W-1:0] data_i,
  output logic              commit_o,
  output logic [IDX_W-1:0]  cidx_o,
  output logic [LANE_W-1:0] cdata_o
);
  logic              win_q,  win_d;
  logic [IDX_W-1:0]  idx_q,  idx_d;
  logic [LANE_W-1:0] data_q, data_d;
  logic              cap_en;

  always_comb begin
    cap_en = win_i;
    win_d  = win_i;
    idx_d  = cap_en ? idx_i  : idx_q;
    data_d = cap_en ? data_i : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win_d;
  end

  always_ff @(posedge clk) begin
    idx_q  <= idx_d;
    data_q <= data_d;
  end

  assign commit_o = win_q & ~win_i;
  assign cidx_o   = idx_q;
  assign cdata_o  = data_q;
endmodule

// File: rtl/bls_byte_array.sv
module bls_byte_array #(
  parameter int DEPTH  = 256,
  parameter int LANE_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [LANE_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [LANE_W-1:0] rdata
);
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/bls_sram.sv
module bls_sram
  import bls_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              ce,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              drv_lo,
  output logic              drv_hi,
  output logic              standby
);
  logic [LANES-1:0] ben_n;
  lane_mode_e       mode [LANES];
  logic [LANES-1:0] drv;
  logic [IDX_W-1:0] idx;

  assign ben_n = {ub_n, lb_n};
  assign idx   = addr[IDX_W-1:0];

  if (ADDR_W > IDX_W) begin : g_hi_addr
    logic addr_unused;
    assign addr_unused = ^addr[ADDR_W-1:IDX_W];
  end

  bls_decode u_dec (
    .ce_n      (ce_n),
    .ce        (ce),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .ben_n     (ben_n),
    .mode_o    (mode),
    .standby_o (standby)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic              win;
    logic              commit;
    logic [IDX_W-1:0]  cidx;
    logic [LANE_W-1:0] cdata;
    logic [LANE_W-1:0] rdata;

    assign win = (mode[l] == LANE_WRITE);

    bls_lane_commit #(.IDX_W(IDX_W), .LANE_W(LANE_W)) u_commit (
      .clk      (clk),
      .rst_n    (rst_n),
      .win_i    (win),
      .idx_i    (idx),
      .data_i   (din[l*LANE_W +: LANE_W]),
      .commit_o (commit),
      .cidx_o   (cidx),
      .cdata_o  (cdata)
    );

    bls_byte_array #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u_arr (
      .clk   (clk),
      .we    (commit),
      .widx  (cidx),
      .wdata (cdata),
      .ridx  (idx),
      .rdata (rdata)
    );

    assign drv[l] = (mode[l] == LANE_READ);
    assign dout[l*LANE_W +: LANE_W] = drv[l] ? rdata : '0;
  end

  assign drv_lo = drv[0];
  assign drv_hi = drv[1];
endmodule

// File: rtl/bls_sram_chk.sv
module bls_sram_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              ce,
  input logic              we_n,
  input logic              oe_n,
  input logic              ub_n,
  input logic              lb_n,
  input logic [15:0]       dout,
  input logic              drv_lo,
  input logic              drv_hi,
  input logic              standby
);
  AST_DESELECT_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || !ce) |-> standby);  // R1
  AST_STBY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (!drv_lo && !drv_hi));  // R2
  AST_NOBYTE_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    (ub_n && lb_n) |-> standby);  // R2
  AST_READ_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && ce && we_n && !oe_n && !lb_n) |-> drv_lo);  // R3
  AST_LANE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((lb_n |-> !drv_lo) and (ub_n |-> !drv_hi)));  // R4
  AST_OE_OFF_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && ce && we_n && oe_n && !(ub_n && lb_n)) |-> (!standby && !drv_lo && !drv_hi));  // R5
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n) |-> (!drv_lo && !drv_hi));  // R6
  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((!drv_lo |-> dout[7:0] == 8'h00) and (!drv_hi |-> dout[15:8] == 8'h00)));  // R9
endmodule

bind bls_sram bls_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .ce_n    (ce_n),
  .ce      (ce),
  .we_n    (we_n),
  .oe_n    (oe_n),
  .ub_n    (ub_n),
  .lb_n    (lb_n),
  .dout    (dout),
  .drv_lo  (drv_lo),
  .drv_hi  (drv_hi),
  .standby (standby)
);

// File: tb/sim_bls_sram.sv
module sim_bls_sram;
  localparam int ADDR_W = 18;
  localparam int DEPTH  = 256;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic              ce_n, ce, we_n, oe_n, ub_n, lb_n;
  logic [15:0]       din;
  logic [15:0]       dout;
  logic              drv_lo, drv_hi, standby;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  bls_sram #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .ce(ce),
    .we_n(we_n), .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .din(din),
    .dout(dout), .drv_lo(drv_lo), .drv_hi(drv_hi), .standby(standby)
  );

  // behavioural reference: word store plus one pending write per lane
  logic [15:0] mref [DEPTH];
  logic [1:0]  pwin;
  int          pidx [2];
  logic [7:0]  pdat [2];

  function automatic bit lane_win(int l);
    return !ce_n && ce && !we_n && !((l == 0) ? lb_n : ub_n);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwin <= 2'b00;
    else begin
      for (int l = 0; l < 2; l++) begin
        if (pwin[l] && !lane_win(l)) mref[pidx[l]][l*8 +: 8] <= pdat[l];
        if (lane_win(l)) begin
          pidx[l] <= int'(addr % DEPTH);
          pdat[l] <= din[l*8 +: 8];
        end
        pwin[l] <= lane_win(l);
      end
    end
  end

  function automatic logic [15:0] pat(int i);
    return (16'(i) * 16'h0101) ^ 16'h5a3c;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp();
    bit sel, sb, rd, elo, ehi;
    string tag;
    logic [15:0] w, ed;
    sel = !ce_n && ce;
    sb  = !sel || (ub_n && lb_n);
    rd  = sel && we_n && !oe_n;
    elo = !sb && rd && !lb_n;
    ehi = !sb && rd && !ub_n;
    w   = mref[int'(addr % DEPTH)];
    ed  = {ehi ? w[15:8] : 8'h00, elo ? w[7:0] : 8'h00};
    if (!sel)               tag = "R1";
    else if (ub_n && lb_n)  tag = "R2";
    else if (!we_n)         tag = "R6";
    else if (oe_n)          tag = "R5";
    else if (ub_n ^ lb_n)   tag = "R4";
    else                    tag = "R3";
    chk({tag, " drive"},   {14'd0, drv_hi, drv_lo}, {14'd0, ehi, elo});
    chk({tag, " standby"}, {15'd0, standby}, {15'd0, sb});
    if (rst_n && (elo || ehi || ed == 16'h0)) chk({tag, " data"}, dout, ed);
  endtask

  task automatic cyc(logic [ADDR_W-1:0] a, logic cen, logic cei, logic wen,
                     logic oen, logic ubn, logic lbn, logic [15:0] d);
    @(negedge clk);
    addr = a; ce_n = cen; ce = cei; we_n = wen; oe_n = oen;
    ub_n = ubn; lb_n = lbn; din = d;
    #1 cmp();
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic ubn, logic lbn, logic [15:0] d);
    cyc(a, 0, 1, 0, 1, ubn, lbn, d);
    cyc(a, 0, 1, 1, 1, ubn, lbn, 16'h0);
  endtask

  task automatic rdx(string tag, logic [ADDR_W-1:0] a, logic ubn, logic lbn,
                     logic [15:0] exp);
    cyc(a, 0, 1, 1, 0, ubn, lbn, 16'h0);
    chk(tag, dout, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; addr = '0; ce_n = 1; ce = 0; we_n = 1; oe_n = 1;
    ub_n = 1; lb_n = 1; din = '0;
    repeat (3) @(negedge clk);
    #1 chk("R10 reset standby", {15'd0, standby}, 16'd1);
    chk("R10 reset drive", {14'd0, drv_hi, drv_lo}, 16'd0);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < DEPTH; i++) wr(ADDR_W'(i), 0, 0, pat(i));

    rdx("R3 full read", 18'd3, 0, 0, pat(3));
    rdx("R4 low only", 18'd4, 1, 0, {8'h00, pat(4)[7:0]});
    rdx("R4 high only", 18'd4, 0, 1, {pat(4)[15:8], 8'h00});
    chk("R9 idle lane zero", {8'h00, dout[7:0]}, 16'h0);

    // R7: window held over three cycles with oe_n low, closed by chip enable
    cyc(18'd5, 0, 1, 0, 0, 0, 0, 16'h1111);
    cyc(18'd5, 0, 1, 0, 0, 0, 0, 16'h2222);
    cyc(18'd5, 0, 1, 0, 0, 0, 0, 16'h3333);
    cyc(18'd5, 1, 1, 0, 0, 0, 0, 16'h4444);
    rdx("R7 last data kept", 18'd5, 0, 0, 16'h3333);

    // R7: not visible before the closing edge
    cyc(18'd6, 0, 1, 0, 1, 0, 0, 16'hBEEF);
    rdx("R7 old before commit", 18'd6, 0, 0, pat(6));
    rdx("R7 new after commit", 18'd6, 0, 0, 16'hBEEF);

    // R7/R6: lanes closing on different edges
    cyc(18'd7, 0, 1, 0, 1, 0, 0, 16'h1234);
    cyc(18'd7, 0, 1, 0, 1, 0, 1, 16'h5678);
    cyc(18'd7, 0, 1, 1, 1, 0, 1, 16'h0000);
    rdx("R7 staggered lanes", 18'd7, 0, 0, 16'h5634);

    wr(18'd8, 1, 0, 16'hFFFF);
    rdx("R6 masked upper lane", 18'd8, 0, 0, {pat(8)[15:8], 8'hFF});

    wr(18'(9 + DEPTH), 0, 0, 16'hA5A5);
    rdx("R8 alias write", 18'd9, 0, 0, 16'hA5A5);
    rdx("R8 alias read", 18'h20009, 0, 0, 16'hA5A5);

    cyc(18'd10, 0, 0, 0, 1, 0, 0, 16'h0F0F);
    cyc(18'd10, 1, 1, 0, 1, 0, 0, 16'h0F0F);
    cyc(18'd10, 1, 0, 1, 1, 0, 0, 16'h0);
    rdx("R1 deselected write ignored", 18'd10, 0, 0, pat(10));

    cyc(18'd11, 0, 1, 0, 0, 1, 1, 16'h7777);
    cyc(18'd11, 0, 1, 1, 1, 1, 1, 16'h0);
    rdx("R2 no byte write ignored", 18'd11, 0, 0, pat(11));

    // R10: window open at reset assertion commits nothing
    cyc(18'd12, 0, 1, 0, 1, 0, 0, 16'hDEAD);
    @(negedge clk) rst_n = 0;
    @(negedge clk) we_n = 1;
    @(negedge clk) rst_n = 1;
    rdx("R10 reset drops window", 18'd12, 0, 0, pat(12));

    for (int n = 0; n < 4000; n++) begin
      logic [6:0] r;
      r = 7'($urandom);
      cyc(18'($urandom % 8) | ((r[6]) ? 18'(DEPTH) : 18'd0),
          r[0] & r[5], r[1] | r[5], r[2], r[3], r[4] & r[0], r[4] & r[1],
          16'($urandom));
    end

    finish_run();
  end
endmodule